// File: doc/BRIEF.md
# Program/Erase Suspend-Resume Controller

This controller sits between the SPI command decoder of a serial NOR flash and its embedded-operation sequencer. It records which embedded operation is in flight: an erase, a program, or a program nested inside a suspended erase. It turns host suspend and resume opcodes into a suspend request and a resume pulse toward the sequencer.

It keeps a read-only second status register that shows which kind of operation is held. It also produces two permit flags for the sector a new command aims at. The decoder uses these flags to accept or reject a read or a program while an operation is held.

Suspend entry has a latency budget, and a resume must be followed by a minimum stretch of progress before the next suspend of the same kind is honoured. Both are counted in clock cycles derived from a clock-frequency parameter (`CLK_MHZ`) and microsecond parameters. A suspend that arrives inside the progress window is remembered and takes effect when the window closes. A software reset abandons everything.

Top module: `psr_ctrl`

## Requirements
- R1: A command with opcode 07h makes `sr2_rd_valid` high in the next cycle, with `sr2_rd_data` equal to the status value as it stood in the command cycle.
- R2: Status bit 1 is set while an erase is held and bit 0 while a program is held; bits 7 to 2 are always zero, and no opcode writes the register.
- R3: With nothing running, reads and programs are permitted to any sector. While an operation is running or entering suspend, neither is permitted. While an erase is held, reads and programs are permitted only to other sectors. While a program is held, only reads to sectors other than the held program sector (and the held erase sector) are permitted.
- R4: An accepted suspend (75h erase, 85h program) raises `eng_susp_req` in the next cycle. The held bit is set in the cycle after `eng_paused` is seen, or after `ERS_LAT_US*CLK_MHZ` (erase) or `PGM_LAT_US*CLK_MHZ` (program) cycles of request, whichever comes first.
- R5: A suspend opcode with no running operation of that kind, and a resume opcode (7Ah erase, 8Ah program) with nothing of that kind held, have no effect.
- R6: An accepted resume clears the held bit and pulses `eng_resume` for one cycle, both in the next cycle.
- R7: A suspend arriving within `DWELL_US*CLK_MHZ` cycles after a resume of the same kind is kept pending. `eng_susp_req` then rises exactly `DWELL_US*CLK_MHZ+1` cycles after the `eng_resume` pulse cycle.
- R8: A program started while an erase is held can be program-suspended. Erase resume is ignored while that program exists (running, entering suspend, or held), and also when it arrives in the same cycle as an accepted program start.
- R9: `sw_reset` clears both held bits, drops the request, pulses `eng_abort` in the next cycle, and abandons all operations, so both permits return for every sector.
- R10: `eng_done` retires the innermost running or suspending operation without setting a held bit and drops its pending suspend. A suspend opcode in the same cycle as `eng_done` for that operation is ignored.
- R11: `eng_start` for an erase is accepted only when nothing is active. A program start is accepted only when `pg_permit` would hold for its sector; otherwise the start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded host opcode present this cycle |
| cmd_op | input | 8 | Decoded opcode |
| cmd_sector | input | SECTOR_W | Sector targeted by the current host command |
| sw_reset | input | 1 | Software reset strobe from the decoder |
| eng_start | input | 1 | Sequencer begins a new operation |
| eng_is_erase | input | 1 | Started operation is an erase (else program) |
| eng_sector | input | SECTOR_W | Sector of the started operation |
| eng_paused | input | 1 | Sequencer has reached a safe pause point |
| eng_done | input | 1 | Innermost active operation finished |
| eng_susp_req | output | 1 | Suspend request to the sequencer |
| eng_resume | output | 1 | One-cycle resume pulse to the sequencer |
| eng_abort | output | 1 | One-cycle abandon pulse after software reset |
| sr2 | output | 8 | Status register 2 |
| sr2_rd_valid | output | 1 | Status read response valid |
| sr2_rd_data | output | 8 | Status read response data |
| rd_permit | output | 1 | A read to `cmd_sector` may be accepted |
| pg_permit | output | 1 | A program to `cmd_sector` may be accepted |

## Verification
Two kinds of collision are provoked on purpose. In the first, the sequencer reports completion in the same cycle as a suspend opcode for that operation. In the second, a pending suspend is left waiting while the operation finishes. In both, the status register must stay clear and no request may appear. A second pairing drives an erase resume while a nested program still exists, and expects it to be ignored. A behavioural model in the bench tracks each operation with plain integers and is compared against every output on every cycle. Directed checks pin the exact cycle of timeout entry and of the end of the progress window.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        CTX_IDLE    = 2'd0,
        CTX_RUN     = 2'd1,
        CTX_HALTING = 2'd2,
        CTX_HELD    = 2'd3
    } ctx_e;

    localparam logic [7:0] OP_RD_SR2   = 8'h07;
    localparam logic [7:0] OP_ERS_SUSP = 8'h75;
    localparam logic [7:0] OP_ERS_RES  = 8'h7A;
    localparam logic [7:0] OP_PGM_SUSP = 8'h85;
    localparam logic [7:0] OP_PGM_RES  = 8'h8A;

    // index of each kind in per-kind vectors; equals its status bit
    localparam int KIND_PGM = 0;
    localparam int KIND_ERS = 1;
endpackage

// File: rtl/psr_countdown.sv
module psr_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/psr_permit.sv
module psr_permit
    import psr_pkg::*;
#(
    parameter int SECTOR_W = 8
) (
    input  ctx_e                ers_st,
    input  ctx_e                pgm_st,
    input  logic [SECTOR_W-1:0] ers_sec,
    input  logic [SECTOR_W-1:0] pgm_sec,
    input  logic [SECTOR_W-1:0] sector,
    output logic                rd_ok,
    output logic                pg_ok
);
    logic busy;
    logic hit_ers;
    logic hit_pgm;

    always_comb begin
        busy    = (ers_st == CTX_RUN) || (ers_st == CTX_HALTING) ||
                  (pgm_st == CTX_RUN) || (pgm_st == CTX_HALTING);
        hit_ers = (ers_st == CTX_HELD) && (sector == ers_sec);
        hit_pgm = (pgm_st == CTX_HELD) && (sector == pgm_sec);
        rd_ok   = !busy && !hit_ers && !hit_pgm;
        pg_ok   = !busy && (pgm_st == CTX_IDLE) && !hit_ers;
    end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
    import psr_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int SECTOR_W   = 8,
    parameter int ERS_LAT_US = 45,
    parameter int PGM_LAT_US = 40,
    parameter int DWELL_US   = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_op,
    input  logic [SECTOR_W-1:0] cmd_sector,
    input  logic                sw_reset,
    input  logic                eng_start,
    input  logic                eng_is_erase,
    input  logic [SECTOR_W-1:0] eng_sector,
    input  logic                eng_paused,
    input  logic                eng_done,
    output logic                eng_susp_req,
    output logic                eng_resume,
    output logic                eng_abort,
    output logic [7:0]          sr2,
    output logic                sr2_rd_valid,
    output logic [7:0]          sr2_rd_data,
    output logic                rd_permit,
    output logic                pg_permit
);
    localparam int ERS_LAT_CYC = ERS_LAT_US * CLK_MHZ;
    localparam int PGM_LAT_CYC = PGM_LAT_US * CLK_MHZ;
    localparam int DWELL_CYC   = DWELL_US * CLK_MHZ;
    localparam int LAT_MAX     = (ERS_LAT_CYC > PGM_LAT_CYC) ? ERS_LAT_CYC : PGM_LAT_CYC;
    localparam int CNT_MAX     = (LAT_MAX > DWELL_CYC) ? LAT_MAX : DWELL_CYC;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ERS_LOAD   = CNT_W'(ERS_LAT_CYC - 1);
    localparam logic [CNT_W-1:0] PGM_LOAD   = CNT_W'(PGM_LAT_CYC - 1);
    localparam logic [CNT_W-1:0] DWELL_LOAD = CNT_W'(DWELL_CYC);

    typedef struct packed {
        ctx_e                ers_st;
        ctx_e                pgm_st;
        logic [SECTOR_W-1:0] ers_sec;
        logic [SECTOR_W-1:0] pgm_sec;
        logic                ers_pend;
        logic                pgm_pend;
        logic                resume;
        logic                abort;
        logic                rd_valid;
        logic [7:0]          rd_data;
    } state_t;

    state_t q, d;

    logic [1:0]       dw_load, dw_clr, dw_zero;
    logic             lat_load, lat_clr, lat_zero;
    logic [CNT_W-1:0] lat_val;
    logic             st_pg_ok, st_rd_ok;
    logic [7:0]       sr2_now;

    // progress-window timers, one per operation kind
    for (genvar k = 0; k < 2; k++) begin : g_dwell
        psr_countdown #(.W(CNT_W)) u_dwell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (dw_clr[k]),
            .load     (dw_load[k]),
            .load_val (DWELL_LOAD),
            .zero     (dw_zero[k])
        );
    end

    // suspend-entry latency budget, shared: only one operation halts at a time
    psr_countdown #(.W(CNT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lat_clr),
        .load     (lat_load),
        .load_val (lat_val),
        .zero     (lat_zero)
    );

    psr_permit #(.SECTOR_W(SECTOR_W)) u_cmd_permit (
        .ers_st  (q.ers_st),
        .pgm_st  (q.pgm_st),
        .ers_sec (q.ers_sec),
        .pgm_sec (q.pgm_sec),
        .sector  (cmd_sector),
        .rd_ok   (rd_permit),
        .pg_ok   (pg_permit)
    );

    psr_permit #(.SECTOR_W(SECTOR_W)) u_start_permit (
        .ers_st  (q.ers_st),
        .pgm_st  (q.pgm_st),
        .ers_sec (q.ers_sec),
        .pgm_sec (q.pgm_sec),
        .sector  (eng_sector),
        .rd_ok   (st_rd_ok),
        .pg_ok   (st_pg_ok)
    );

    assign sr2_now = {6'b0, q.ers_st == CTX_HELD, q.pgm_st == CTX_HELD};

    always_comb begin
        logic ers_active, pgm_active;
        logic e_done, p_done, pgm_start_ok;

        d          = q;
        d.resume   = 1'b0;
        d.abort    = 1'b0;
        d.rd_valid = 1'b0;
        dw_load    = 2'b00;
        dw_clr     = 2'b00;
        lat_load   = 1'b0;
        lat_clr    = 1'b0;
        lat_val    = ERS_LOAD;

        ers_active   = (q.ers_st == CTX_RUN) || (q.ers_st == CTX_HALTING);
        pgm_active   = (q.pgm_st == CTX_RUN) || (q.pgm_st == CTX_HALTING);
        e_done       = 1'b0;
        p_done       = 1'b0;
        pgm_start_ok = eng_start && !eng_is_erase && st_pg_ok;

        if (sw_reset) begin
            d.ers_st   = CTX_IDLE;
            d.pgm_st   = CTX_IDLE;
            d.ers_pend = 1'b0;
            d.pgm_pend = 1'b0;
            d.abort    = 1'b1;
            dw_clr     = 2'b11;
            lat_clr    = 1'b1;
        end else begin
            if (cmd_valid && cmd_op == OP_RD_SR2) begin
                d.rd_valid = 1'b1;
                d.rd_data  = sr2_now;
            end

            // completion goes to the innermost live operation
            if (eng_done) begin
                if (pgm_active) begin
                    d.pgm_st         = CTX_IDLE;
                    d.pgm_pend       = 1'b0;
                    p_done           = 1'b1;
                    dw_clr[KIND_PGM] = 1'b1;
                end else if (q.pgm_st == CTX_IDLE && ers_active) begin
                    d.ers_st         = CTX_IDLE;
                    d.ers_pend       = 1'b0;
                    e_done           = 1'b1;
                    dw_clr[KIND_ERS] = 1'b1;
                end
            end

            // pause acknowledge or latency budget spent
            if (q.pgm_st == CTX_HALTING && !p_done && (eng_paused || lat_zero)) begin
                d.pgm_st = CTX_HELD;
            end
            if (q.ers_st == CTX_HALTING && !e_done && (eng_paused || lat_zero)) begin
                d.ers_st = CTX_HELD;
            end

            if (eng_start) begin
                if (eng_is_erase) begin
                    if (q.ers_st == CTX_IDLE && q.pgm_st == CTX_IDLE) begin
                        d.ers_st  = CTX_RUN;
                        d.ers_sec = eng_sector;
                    end
                end else if (pgm_start_ok) begin
                    d.pgm_st  = CTX_RUN;
                    d.pgm_sec = eng_sector;
                end
            end

            if (cmd_valid) begin
                case (cmd_op)
                    OP_ERS_SUSP: begin
                        if (q.ers_st == CTX_RUN && q.pgm_st == CTX_IDLE && !e_done) begin
                            if (dw_zero[KIND_ERS]) begin
                                d.ers_st   = CTX_HALTING;
                                d.ers_pend = 1'b0;
                                lat_load   = 1'b1;
                                lat_val    = ERS_LOAD;
                            end else begin
                                d.ers_pend = 1'b1;
                            end
                        end
                    end
                    OP_PGM_SUSP: begin
                        if (q.pgm_st == CTX_RUN && !p_done) begin
                            if (dw_zero[KIND_PGM]) begin
                                d.pgm_st   = CTX_HALTING;
                                d.pgm_pend = 1'b0;
                                lat_load   = 1'b1;
                                lat_val    = PGM_LOAD;
                            end else begin
                                d.pgm_pend = 1'b1;
                            end
                        end
                    end
                    OP_ERS_RES: begin
                        if (q.ers_st == CTX_HELD && q.pgm_st == CTX_IDLE && !pgm_start_ok) begin
                            d.ers_st          = CTX_RUN;
                            d.resume          = 1'b1;
                            dw_load[KIND_ERS] = 1'b1;
                        end
                    end
                    OP_PGM_RES: begin
                        if (q.pgm_st == CTX_HELD) begin
                            d.pgm_st          = CTX_RUN;
                            d.resume          = 1'b1;
                            dw_load[KIND_PGM] = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            // a held-back suspend fires once its window has closed
            if (q.ers_st == CTX_RUN && q.ers_pend && dw_zero[KIND_ERS] && !e_done) begin
                d.ers_st   = CTX_HALTING;
                d.ers_pend = 1'b0;
                lat_load   = 1'b1;
                lat_val    = ERS_LOAD;
            end
            if (q.pgm_st == CTX_RUN && q.pgm_pend && dw_zero[KIND_PGM] && !p_done) begin
                d.pgm_st   = CTX_HALTING;
                d.pgm_pend = 1'b0;
                lat_load   = 1'b1;
                lat_val    = PGM_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ers_st: CTX_IDLE, pgm_st: CTX_IDLE, ers_sec: '0, pgm_sec: '0,
                   ers_pend: 1'b0, pgm_pend: 1'b0, resume: 1'b0, abort: 1'b0,
                   rd_valid: 1'b0, rd_data: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign eng_susp_req = (q.ers_st == CTX_HALTING) || (q.pgm_st == CTX_HALTING);
    assign eng_resume   = q.resume;
    assign eng_abort    = q.abort;
    assign sr2          = sr2_now;
    assign sr2_rd_valid = q.rd_valid;
    assign sr2_rd_data  = q.rd_data;

    // R3: any sector open to programming is also open to reading
    a_r3_pg_implies_rd: assert property (@(posedge clk) disable iff (!rst_n)
        pg_permit |-> rd_permit);

    // R4: a held bit only appears after the request was raised
    a_r4_bit_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr2[0]) |-> $past(eng_susp_req));

    // R5: a program resume with nothing held never produces a resume pulse
    a_r5_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PGM_RES && q.pgm_st != CTX_HELD && !sw_reset)
        |=> !eng_resume);

    // R6: an accepted erase resume clears the bit and pulses the sequencer
    a_r6_ers_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERS_RES && q.ers_st == CTX_HELD &&
         q.pgm_st == CTX_IDLE && !sw_reset && !eng_start)
        |=> (!sr2[1] && eng_resume));

    // R7: inside the progress window a program never starts halting
    a_r7_dwell_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pgm_st == CTX_RUN && !dw_zero[KIND_PGM]) |=> (q.pgm_st != CTX_HALTING));

    // R9: software reset leaves a clean status and an abort pulse
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (sr2 == 8'h00 && !eng_susp_req && eng_abort));
endmodule

// File: tb/psr_ctrl_tb.sv
module psr_ctrl_tb;
    localparam int CLK_MHZ = 1;
    localparam int EL = 45 * CLK_MHZ;
    localparam int PL = 40 * CLK_MHZ;
    localparam int DW = 100 * CLK_MHZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic [7:0] cmd_sector = 8'h00;
    logic       sw_reset = 1'b0;
    logic       eng_start = 1'b0;
    logic       eng_is_erase = 1'b0;
    logic [7:0] eng_sector = 8'h00;
    logic       eng_paused = 1'b0;
    logic       eng_done = 1'b0;
    logic       eng_susp_req, eng_resume, eng_abort;
    logic [7:0] sr2;
    logic       sr2_rd_valid;
    logic [7:0] sr2_rd_data;
    logic       rd_permit, pg_permit;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    psr_ctrl #(.CLK_MHZ(CLK_MHZ), .SECTOR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .sw_reset(sw_reset), .eng_start(eng_start),
        .eng_is_erase(eng_is_erase), .eng_sector(eng_sector),
        .eng_paused(eng_paused), .eng_done(eng_done),
        .eng_susp_req(eng_susp_req), .eng_resume(eng_resume), .eng_abort(eng_abort),
        .sr2(sr2), .sr2_rd_valid(sr2_rd_valid), .sr2_rd_data(sr2_rd_data),
        .rd_permit(rd_permit), .pg_permit(pg_permit)
    );

    // ---------------- behavioural reference: 0 idle, 1 run, 2 halting, 3 held
    int me = 0, mp = 0, mesec = 0, mpsec = 0;
    bit mepend = 0, mppend = 0;
    int medw = 0, mpdw = 0, mlat = 0;
    bit x_res = 0, x_abort = 0, x_rdv = 0;
    int x_rdd = 0;

    function automatic bit m_rd(int sec);
        bit busy = (me == 1 || me == 2 || mp == 1 || mp == 2);
        return !busy && !(me == 3 && sec == mesec) && !(mp == 3 && sec == mpsec);
    endfunction

    function automatic bit m_pg(int sec);
        bit busy = (me == 1 || me == 2 || mp == 1 || mp == 2);
        return !busy && mp == 0 && !(me == 3 && sec == mesec);
    endfunction

    always @(posedge clk) begin
        int e0, p0;
        bit ez, pz, edn, pdn, eres, pres, pstart;
        if (!rst_n) begin
            me = 0; mp = 0; mepend = 0; mppend = 0; medw = 0; mpdw = 0; mlat = 0;
            x_res = 0; x_abort = 0; x_rdv = 0; x_rdd = 0;
        end else begin
            e0 = me; p0 = mp; ez = (medw == 0); pz = (mpdw == 0);
            edn = 0; pdn = 0; eres = 0; pres = 0;
            pstart = eng_start && !eng_is_erase && m_pg(int'(eng_sector));
            x_res = 0; x_abort = 0; x_rdv = 0;
            if (sw_reset) begin
                me = 0; mp = 0; mepend = 0; mppend = 0; medw = 0; mpdw = 0; x_abort = 1;
            end else begin
                if (cmd_valid && cmd_op == 8'h07) begin
                    x_rdv = 1; x_rdd = (e0 == 3 ? 2 : 0) + (p0 == 3 ? 1 : 0);
                end
                if (eng_done) begin
                    if (p0 == 1 || p0 == 2) begin mp = 0; mppend = 0; pdn = 1; end
                    else if (p0 == 0 && (e0 == 1 || e0 == 2)) begin me = 0; mepend = 0; edn = 1; end
                end
                if (p0 == 2 && !pdn) begin mlat++; if (eng_paused || mlat >= PL) mp = 3; end
                if (e0 == 2 && !edn) begin mlat++; if (eng_paused || mlat >= EL) me = 3; end
                if (eng_start) begin
                    if (eng_is_erase) begin
                        if (e0 == 0 && p0 == 0) begin me = 1; mesec = int'(eng_sector); end
                    end else if (pstart) begin
                        mp = 1; mpsec = int'(eng_sector);
                    end
                end
                if (cmd_valid) begin
                    if (cmd_op == 8'h75 && e0 == 1 && p0 == 0 && !edn) begin
                        if (ez) begin me = 2; mlat = 0; mepend = 0; end else mepend = 1;
                    end
                    if (cmd_op == 8'h85 && p0 == 1 && !pdn) begin
                        if (pz) begin mp = 2; mlat = 0; mppend = 0; end else mppend = 1;
                    end
                    if (cmd_op == 8'h7A && e0 == 3 && p0 == 0 && !pstart) begin
                        me = 1; x_res = 1; eres = 1;
                    end
                    if (cmd_op == 8'h8A && p0 == 3) begin mp = 1; x_res = 1; pres = 1; end
                end
                if (e0 == 1 && mepend && ez && !edn) begin me = 2; mlat = 0; mepend = 0; end
                if (p0 == 1 && mppend && pz && !pdn) begin mp = 2; mlat = 0; mppend = 0; end
                if (edn) medw = 0; else if (eres) medw = DW; else if (medw > 0) medw--;
                if (pdn) mpdw = 0; else if (pres) mpdw = DW; else if (mpdw > 0) mpdw--;
            end
        end
    end

    // ---------------- checking helpers
    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R2 sr2 vs model", int'(sr2), (me == 3 ? 2 : 0) + (mp == 3 ? 1 : 0));
        chk("R4 susp_req vs model", int'(eng_susp_req), int'(me == 2 || mp == 2));
        chk("R6 resume vs model", int'(eng_resume), int'(x_res));
        chk("R9 abort vs model", int'(eng_abort), int'(x_abort));
        chk("R3 rd_permit vs model", int'(rd_permit), int'(m_rd(int'(cmd_sector))));
        chk("R3 pg_permit vs model", int'(pg_permit), int'(m_pg(int'(cmd_sector))));
        chk("R1 rd_valid vs model", int'(sr2_rd_valid), int'(x_rdv));
        if (x_rdv) chk("R1 rd_data vs model", int'(sr2_rd_data), x_rdd);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] sec);
        cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec;
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic start(input logic ers, input logic [7:0] sec);
        eng_start = 1'b1; eng_is_erase = ers; eng_sector = sec;
        cyc();
        eng_start = 1'b0;
    endtask

    task automatic peek(input logic [7:0] sec);
        cmd_sector = sec;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 reset sr2", int'(sr2), 0);
        chk("R3 reset rd_permit", int'(rd_permit), 1);
        chk("R3 reset pg_permit", int'(pg_permit), 1);
        @(negedge clk);

        // R5: suspend and resume with nothing active
        cmd(8'h75, 8'd0);
        chk("R5 idle erase suspend", int'(eng_susp_req), 0);
        cmd(8'h8A, 8'd0);
        chk("R5 idle program resume", int'(eng_resume), 0);

        // erase on sector 5; program start while busy ignored (R11)
        start(1'b1, 8'd5);
        peek(8'd9);
        chk("R3 busy rd_permit", int'(rd_permit), 0);
        chk("R3 busy pg_permit", int'(pg_permit), 0);
        start(1'b0, 8'd9);
        cmd(8'h85, 8'd0);
        chk("R11 program start refused while erasing", int'(eng_susp_req), 0);

        // R4: erase suspend entered by latency timeout
        cmd(8'h75, 8'd0);
        chk("R4 request raised", int'(eng_susp_req), 1);
        repeat (EL - 1) cyc();
        chk("R4 not yet held", int'(sr2), 0);
        chk("R4 request still high", int'(eng_susp_req), 1);
        cyc();
        chk("R4 held at timeout", int'(sr2), 2);
        chk("R4 request dropped", int'(eng_susp_req), 0);

        peek(8'd5);
        chk("R3 erase-held own sector rd", int'(rd_permit), 0);
        chk("R3 erase-held own sector pg", int'(pg_permit), 0);
        peek(8'd6);
        chk("R3 erase-held other rd", int'(rd_permit), 1);
        chk("R3 erase-held other pg", int'(pg_permit), 1);

        cmd(8'h07, 8'd6);
        chk("R1 status read valid", int'(sr2_rd_valid), 1);
        chk("R1 status read data", int'(sr2_rd_data), 2);

        // R8: nested program on sector 6
        start(1'b0, 8'd6);
        cmd(8'h7A, 8'd7);
        chk("R8 erase resume ignored with program running", int'(eng_resume), 0);
        chk("R8 erase still held", int'(sr2), 2);
        cmd(8'h85, 8'd7);
        chk("R8 nested program suspend requested", int'(eng_susp_req), 1);
        cyc(); cyc();
        eng_paused = 1'b1;
        cyc();
        eng_paused = 1'b0;
        chk("R4 held on pause acknowledge", int'(sr2), 3);
        peek(8'd6);
        chk("R3 program-held own sector rd", int'(rd_permit), 0);
        peek(8'd5);
        chk("R3 erase sector rd while both held", int'(rd_permit), 0);
        peek(8'd7);
        chk("R3 program-held other rd", int'(rd_permit), 1);
        chk("R3 program-held other pg", int'(pg_permit), 0);
        cmd(8'h7A, 8'd7);
        chk("R8 erase resume ignored with program held", int'(eng_resume), 0);

        // R6 then R7: resume, early suspend kept pending
        cmd(8'h8A, 8'd7);
        chk("R6 program resume pulse", int'(eng_resume), 1);
        chk("R6 program bit cleared", int'(sr2), 2);
        cmd(8'h85, 8'd7);
        chk("R7 suspend held back", int'(eng_susp_req), 0);
        repeat (DW - 1) cyc();
        chk("R7 window still open", int'(eng_susp_req), 0);
        cyc();
        chk("R7 pending suspend fires", int'(eng_susp_req), 1);
        eng_paused = 1'b1;
        cyc();
        eng_paused = 1'b0;
        chk("R7 program held after window", int'(sr2), 3);

        // R10: program resumed then completes
        cmd(8'h8A, 8'd7);
        cyc(); cyc();
        eng_done = 1'b1;
        cyc();
        eng_done = 1'b0;
        chk("R10 program retired", int'(sr2), 2);
        cmd(8'h7A, 8'd7);
        chk("R8 erase resume accepted after program", int'(eng_resume), 1);
        chk("R6 erase bit cleared", int'(sr2), 0);

        // R10: pending erase suspend dropped on completion
        cmd(8'h75, 8'd7);
        chk("R7 erase suspend pending", int'(eng_susp_req), 0);
        eng_done = 1'b1;
        cyc();
        eng_done = 1'b0;
        repeat (DW + 5) cyc();
        chk("R10 pending dropped no request", int'(eng_susp_req), 0);
        chk("R10 pending dropped status", int'(sr2), 0);

        // R10: completion and suspend in the same cycle
        start(1'b1, 8'd3);
        eng_done = 1'b1; cmd_valid = 1'b1; cmd_op = 8'h75;
        cyc();
        eng_done = 1'b0; cmd_valid = 1'b0;
        chk("R10 same-cycle suspend ignored", int'(eng_susp_req), 0);
        cyc(); cyc();
        chk("R10 same-cycle status clear", int'(sr2), 0);

        // R8: erase resume same cycle as a program start: start wins
        start(1'b1, 8'd4);
        cmd(8'h75, 8'd0);
        eng_paused = 1'b1;
        cyc();
        eng_paused = 1'b0;
        chk("R4 erase held for collision", int'(sr2), 2);
        eng_start = 1'b1; eng_is_erase = 1'b0; eng_sector = 8'd8;
        cmd_valid = 1'b1; cmd_op = 8'h7A;
        cyc();
        eng_start = 1'b0; cmd_valid = 1'b0;
        chk("R8 resume beside start ignored", int'(eng_resume), 0);
        chk("R8 erase remains held", int'(sr2), 2);

        // R9: software reset with erase held and program running
        sw_reset = 1'b1;
        cyc();
        sw_reset = 1'b0;
        chk("R9 abort pulse", int'(eng_abort), 1);
        chk("R9 status cleared", int'(sr2), 0);
        peek(8'd4);
        chk("R9 rd permitted after reset", int'(rd_permit), 1);
        chk("R9 pg permitted after reset", int'(pg_permit), 1);
        cyc();
        chk("R9 abort one cycle", int'(eng_abort), 0);

        repeat (4) cyc();
        summary();
    end
endmodule